// File: doc/BRIEF.md
# Power-State Interrupt Status and Mask Registers

This block keeps a small pair of registers that record power-management state-change requests arriving from a bus host and turn them into a local interrupt. The power-management logic sends single-cycle event pulses: one for a request to enter the low-power state D3, and one for a request to return to the normal state D0. Each pulse sets a sticky bit in a status register. Software clears a bit by writing 1 to it.

A mask register selects which latched events drive the interrupt line. Both registers are 32 bits wide and sit on a simple local register bus with read and write strobes, an address and write data. Read data is registered.

Only the asynchronous power-on reset clears the two registers. A software-reset input is present but leaves both registers unchanged, so a pending power request is not lost when software resets itself. For a short guard window after power-on reset is released, D0 pulses are dropped. This keeps the power-up sequence from appearing as a restore request.

Top module: `pm_irq_regs`

## Requirements
- R1: While power-on reset is asserted, and right after it is released, the status register, the mask register, rdData and irq are all zero.
- R2: A d3Evt pulse sets status bit 1, and an accepted d0Evt pulse sets status bit 0. A set bit stays set until it is cleared.
- R3: A write to the status register at offset 0x0 clears every bit whose write-data bit is 1. A write-data bit of 0 leaves the matching status bit unchanged.
- R4: Bits 31 to 2 of both registers always read as 0, and writes to those bits have no effect.
- R5: A d0Evt pulse in any of the first GUARD_CYCLES clock cycles after power-on reset is released is dropped. A d3Evt pulse in the same window is latched.
- R6: A write to offset 0x4 loads mask bits 1:0 from write data; a mask bit of 1 enables that event. irq = (status[1] & mask[1]) | (status[0] & mask[0]). It is computed combinationally from the registers, so it follows a register change in the same cycle.
- R7: If an event pulse and a write-one-to-clear of the same status bit fall in the same cycle, the bit ends up set.
- R8: Asserting swRst has no effect on the status register, the mask register or irq.
- R9: rdData holds the addressed register one cycle after rdEn: status at 0x0, mask at 0x4. A read of any other address returns 0, and a write to any other address changes nothing. rdData keeps its value when rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| swRst | input | 1 | Software reset; does not affect these registers |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| d3Evt | input | 1 | Pulse: request to enter D3 |
| d0Evt | input | 1 | Pulse: request to return to D0 |
| irq | output | 1 | Interrupt, active high |

## Verification
The bound checker checks four properties on every cycle:
- a D3 pulse always leaves bit 1 set, even when a clear of that bit arrives in the same cycle;
- a clear with no competing event empties the bit;
- the reserved read bits stay zero, and a mask read returns the mask one cycle later;
- software reset with no other activity leaves both registers stable, and irq stays low while the mask is zero.

Some behaviour only the bench scenarios can show. This includes the exact guard window in which D0 pulses are dropped after power-on, and the end-to-end interrupt values for each combination of status and mask. It also includes the full effect of reset on every port, and the fact that writes to unmapped addresses leave both registers untouched.

// File: rtl/pm_irq_pkg.sv
package pm_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_EVT = 2;
  localparam int EVT_D0  = 0;
  localparam int EVT_D3  = 1;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic rdStatus;
    logic rdMask;
    logic rdAny;
    logic acceptD0;
  } regStrobe_t;
endpackage

// File: rtl/pm_irq_ctrl.sv
module pm_irq_ctrl
  import pm_irq_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int STATUS_OFS   = 0,
  parameter int MASK_OFS     = 4,
  parameter int GUARD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe
);
  localparam int CNT_W = $clog2(GUARD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GUARD_CYCLES);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MASK_A   = ADDR_W'(MASK_OFS);

  logic [CNT_W-1:0] guardCnt;
  logic             guardDone;

  // Power-up guard window: counts clock cycles after power-on reset release
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      guardCnt <= '0;
    end else if (!guardDone) begin
      guardCnt <= guardCnt + 1'b1;
    end
  end

  assign guardDone = (guardCnt == CNT_MAX);

  always_comb begin
    strobe          = '0;
    strobe.wrStatus = wrEn && (addr == STATUS_A);
    strobe.wrMask   = wrEn && (addr == MASK_A);
    strobe.rdStatus = rdEn && (addr == STATUS_A);
    strobe.rdMask   = rdEn && (addr == MASK_A);
    strobe.rdAny    = rdEn;
    strobe.acceptD0 = guardDone;
  end
endmodule

// File: rtl/pm_irq_dp.sv
module pm_irq_dp
  import pm_irq_pkg::*;
(
  input  logic               clk,
  input  logic               porRstN,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               d3Evt,
  input  logic               d0Evt,
  output logic [NUM_EVT-1:0] statusQ,
  output logic [NUM_EVT-1:0] maskQ,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  logic [NUM_EVT-1:0] evtSet;
  logic [NUM_EVT-1:0] evtClr;

  assign evtSet[EVT_D3] = d3Evt;
  assign evtSet[EVT_D0] = d0Evt && strobe.acceptD0;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign evtClr[i] = strobe.wrStatus && wrData[i];

    // Sticky bit; a new event takes priority over a same-cycle clear
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN) begin
        statusQ[i] <= 1'b0;
      end else if (evtSet[i]) begin
        statusQ[i] <= 1'b1;
      end else if (evtClr[i]) begin
        statusQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      maskQ <= '0;
    end else if (strobe.wrMask) begin
      maskQ <= wrData[NUM_EVT-1:0];
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      rdData <= '0;
    end else if (strobe.rdAny) begin
      if (strobe.rdStatus) begin
        rdData <= {{(DATA_W-NUM_EVT){1'b0}}, statusQ};
      end else if (strobe.rdMask) begin
        rdData <= {{(DATA_W-NUM_EVT){1'b0}}, maskQ};
      end else begin
        rdData <= '0;
      end
    end
  end

  assign irq = |(statusQ & maskQ);
endmodule

// File: rtl/pm_irq_regs.sv
module pm_irq_regs
  import pm_irq_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int STATUS_OFS   = 0,
  parameter int MASK_OFS     = 4,
  parameter int GUARD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              swRst,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              d3Evt,
  input  logic              d0Evt,
  output logic              irq
);
  regStrobe_t         strobe;
  logic [NUM_EVT-1:0] statusQ;
  logic [NUM_EVT-1:0] maskQ;
  logic               swRstSeen;

  // Software reset is deliberately not wired to any register
  assign swRstSeen = swRst;

  pm_irq_ctrl #(
    .ADDR_W      (ADDR_W),
    .STATUS_OFS  (STATUS_OFS),
    .MASK_OFS    (MASK_OFS),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) i_ctrl (
    .clk    (clk),
    .porRstN(porRstN),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  pm_irq_dp i_dp (
    .clk    (clk),
    .porRstN(porRstN),
    .strobe (strobe),
    .wrData (wrData),
    .d3Evt  (d3Evt),
    .d0Evt  (d0Evt),
    .statusQ(statusQ),
    .maskQ  (maskQ),
    .rdData (rdData),
    .irq    (irq)
  );
endmodule

// File: rtl/pm_irq_regs_chk.sv
module pm_irq_regs_chk #(
  parameter int ADDR_W     = 4,
  parameter int STATUS_OFS = 0,
  parameter int MASK_OFS   = 4
) (
  input logic              clk,
  input logic              porRstN,
  input logic              swRstSeen,
  input logic              rdEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              d3Evt,
  input logic [1:0]        statusQ,
  input logic [1:0]        maskQ,
  input logic              irq
);
  logic wrSt;
  assign wrSt = wrEn && (addr == ADDR_W'(STATUS_OFS));

  // R2, R7: a D3 event always leaves bit 1 set, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!porRstN)
    d3Evt |=> statusQ[1]);

  // R3: a clear of bit 1 with no competing event empties it
  a_r3_w1c: assert property (@(posedge clk) disable iff (!porRstN)
    (wrSt && wrData[1] && !d3Evt) |=> !statusQ[1]);

  // R4: reserved read bits stay zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!porRstN)
    rdData[31:2] == 30'd0);

  // R9: mask read returns the mask one cycle later
  a_r9_mask_read: assert property (@(posedge clk) disable iff (!porRstN)
    (rdEn && !wrEn && addr == ADDR_W'(MASK_OFS)) |=> (rdData[1:0] == $past(maskQ)));

  // R8: software reset with no other activity changes nothing
  a_r8_swrst_inert: assert property (@(posedge clk) disable iff (!porRstN)
    (swRstSeen && !wrEn && !d3Evt && statusQ == 2'b11) |=> (statusQ == 2'b11));

  // R6: no interrupt while every event is masked
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!porRstN)
    (maskQ == 2'b00) |-> !irq);
endmodule

bind pm_irq_regs pm_irq_regs_chk #(
  .ADDR_W    (ADDR_W),
  .STATUS_OFS(STATUS_OFS),
  .MASK_OFS  (MASK_OFS)
) i_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .swRstSeen(swRstSeen),
  .rdEn     (rdEn),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .rdData   (rdData),
  .d3Evt    (d3Evt),
  .statusQ  (statusQ),
  .maskQ    (maskQ),
  .irq      (irq)
);

// File: tb/test_pm_irq_regs.sv
`timescale 1ns/1ps
module test_pm_irq_regs;
  localparam int GUARD = 4;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        swRst = 1'b0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        d3Evt = 1'b0;
  logic        d0Evt = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pm_irq_regs #(.GUARD_CYCLES(GUARD)) i_pm_irq_regs (
    .clk(clk), .porRstN(porRstN), .swRst(swRst), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .d3Evt(d3Evt),
    .d0Evt(d0Evt), .irq(irq)
  );

  // op: 0 write, 1 read, 2 D3 pulse, 3 D0 pulse
  localparam int NV = 19;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 4'h4, 32'h3,        32'h0, 1'b0},  // R6 enable both
    {2'd1, 4'h4, 32'h0,        32'h3, 1'b0},  // R9 read mask
    {2'd2, 4'h0, 32'h0,        32'h0, 1'b1},  // R2 D3 event
    {2'd1, 4'h0, 32'h0,        32'h2, 1'b1},  // R2 status bit1
    {2'd0, 4'h0, 32'h1,        32'h0, 1'b1},  // R3 clear bit0 only
    {2'd1, 4'h0, 32'h0,        32'h2, 1'b1},  // R3 bit1 untouched
    {2'd0, 4'h0, 32'h2,        32'h0, 1'b0},  // R3 clear bit1
    {2'd1, 4'h0, 32'h0,        32'h0, 1'b0},  // R3
    {2'd3, 4'h0, 32'h0,        32'h0, 1'b1},  // R2 D0 event
    {2'd0, 4'h4, 32'h2,        32'h0, 1'b0},  // R6 mask D0
    {2'd1, 4'h0, 32'h0,        32'h1, 1'b0},  // R6 latched but masked
    {2'd2, 4'h0, 32'h0,        32'h0, 1'b1},  // R6 D3 enabled
    {2'd0, 4'h4, 32'hFFFFFFFC, 32'h0, 1'b0},  // R4 only reserved ones
    {2'd1, 4'h4, 32'h0,        32'h0, 1'b0},  // R4 mask reads 0
    {2'd0, 4'h0, 32'hFFFFFFFF, 32'h0, 1'b0},  // R3 clear all
    {2'd1, 4'h0, 32'h0,        32'h0, 1'b0},  // R3
    {2'd1, 4'h8, 32'h0,        32'h0, 1'b0},  // R9 unmapped read
    {2'd0, 4'h8, 32'h3,        32'h0, 1'b0},  // R9 unmapped write
    {2'd1, 4'h4, 32'h0,        32'h0, 1'b0}   // R9 mask unchanged
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] op, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d;
    wrEn  = (op == 2'd0);
    rdEn  = (op == 2'd1);
    d3Evt = (op == 2'd2);
    d0Evt = (op == 2'd3);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; d3Evt = 1'b0; d0Evt = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdData in reset", rdData, 32'h0);
    check("R1 irq in reset", {31'd0, irq}, 32'h0);
    // Release reset, then pulse both events in the first cycle: R5
    porRstN = 1'b1;
    d0Evt = 1'b1; d3Evt = 1'b1;
    @(negedge clk);
    d0Evt = 1'b0; d3Evt = 1'b0;
    doOp(2'd3, 4'h0, 32'h0);            // still inside guard window
    doOp(2'd1, 4'h0, 32'h0);
    check("R5 D0 dropped, D3 kept", rdData, 32'h2);
    doOp(2'd1, 4'h4, 32'h0);
    check("R1 mask zero after reset", rdData, 32'h0);
    doOp(2'd0, 4'h0, 32'h3);
    doOp(2'd1, 4'h0, 32'h0);
    check("R1 status clear", rdData, 32'h0);

    for (int i = 0; i < NV; i++) begin
      doOp(VEC[i][70:69], VEC[i][68:65], VEC[i][64:33]);
      if (VEC[i][70:69] == 2'd1) check($sformatf("R9 vector %0d rdData", i), rdData, VEC[i][32:1]);
      check($sformatf("R6 vector %0d irq", i), {31'd0, irq}, {31'd0, VEC[i][0]});
    end

    // R7: event and clear of the same bit together
    doOp(2'd0, 4'h4, 32'h3);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'h0; wrData = 32'h3; d3Evt = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; d3Evt = 1'b0;
    doOp(2'd1, 4'h0, 32'h0);
    check("R7 set wins", rdData, 32'h2);

    // R8: software reset leaves both registers and irq alone
    doOp(2'd3, 4'h0, 32'h0);
    @(negedge clk); swRst = 1'b1;
    repeat (3) @(negedge clk);
    swRst = 1'b0;
    check("R8 irq kept", {31'd0, irq}, 32'h1);
    doOp(2'd1, 4'h0, 32'h0);
    check("R8 status kept", rdData, 32'h3);
    doOp(2'd1, 4'h4, 32'h0);
    check("R8 mask kept", rdData, 32'h3);

    // R9: rdData holds without a read strobe
    doOp(2'd0, 4'h4, 32'h1);
    repeat (2) @(negedge clk);
    check("R9 rdData held", rdData, 32'h3);

    // R1: a second power-on reset clears everything
    porRstN = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, irq}, 32'h0);
    check("R1 rdData after reset", rdData, 32'h0);
    porRstN = 1'b1;
    repeat (GUARD + 1) @(negedge clk);
    doOp(2'd3, 4'h0, 32'h0);              // past the guard window
    doOp(2'd1, 4'h0, 32'h0);
    check("R5 D0 accepted after guard", rdData, 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule